// File: doc/BRIEF.md
# Multi-width bit manipulation unit

This execution unit sits beside the ALU of a CPU with an 8-bit heritage and registers up to 64 bits wide. Each cycle it may accept one operand, a size code and an operation code. One clock edge later it returns a 64-bit result and a carry flag, which go back to the accumulator. Every operation acts only on the low 8, 16, 32 or 64 bits that the size code selects. Every result is zero-extended to the full width.

The unit does six things. It swaps the two halves of the operand, where at byte size the halves are the two nibbles. It reverses the bit order. It counts the bits that are 1. It gives the position of the most significant 1. It gives the position of the most significant 0. It negates the operand in two's complement. For the two search operations, carry reports that no qualifying bit exists. The operand source, whether accumulator or memory, is chosen outside the unit. The unit never writes memory.

Top module: `bit_manip_unit`

## Requirements
- R1: With op code 0 (swap) and size code 0 (byte), the result holds the operand's low nibble in bits 7:4 and its bits 7:4 in bits 3:0.
- R2: With op code 0 at size codes 1, 2 and 3 (16, 32 and 64 bits), the result exchanges the two bytes, the two 16-bit halves or the two 32-bit halves of the selected field.
- R3: With op code 1 (reverse), result bit i equals operand bit W-1-i for every i below the selected width W (8, 16, 32 or 64).
- R4: With op code 2 (popcount), the result is the number of 1 bits in the selected field and ranges from 0 to 64.
- R5: With op code 3 (highest set), the result is the index of the most significant 1 in the selected field, and carry is 0.
- R6: With op code 4 (highest clear), the result is the index of the most significant 0 in the selected field, and carry is 0.
- R7: When op code 3 or 4 finds no qualifying bit, carry is 1 and the result is 0. Every other operation leaves carry at 0.
- R8: With op code 5 (negate), the result is the two's complement of the selected field, taken modulo 2^W.
- R9: Operand bits above the selected width have no effect on the result, and result bits above that width are 0.
- R10: Result and carry appear with out_valid high exactly one cycle after an in_valid strobe. out_valid is low after a cycle without a strobe, and the result holds its value until the next strobe.
- R11: During reset and after it, out_valid, out_result and out_carry are 0.
- R12: Op codes 6 and 7 are reserved and give a result of 0 with carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_size | input | 2 | Size code: 0 byte, 1 word, 2 long, 3 quad |
| in_op | input | 3 | Operation code: 0 swap, 1 reverse, 2 popcount, 3 highest set, 4 highest clear, 5 negate |
| in_operand | input | 64 | Operand value |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 64 | Zero-extended result |
| out_carry | output | 1 | Set when a search finds no qualifying bit |

## Verification
The hardest case to reach from the ports is a search that finds nothing while bits above the selected width are set. Only the width masking separates a carry of 1 with result 0 from a valid index in that case. The bench drives such operands on purpose. It sends a byte-size highest-set search with only bit 8 set, and a long-size highest-clear search on all ones. It also runs the same patterns at full width, which confirms that positions 63 and 0 and a popcount of 64 come out correctly.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int NSIZE = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    OP_SWAP = 3'd0,
    OP_REV  = 3'd1,
    OP_POP  = 3'd2,
    OP_HSET = 3'd3,
    OP_HCLR = 3'd4,
    OP_NEG  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;
endpackage

// File: rtl/bmu_swap_rev.sv
module bmu_swap_rev #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] swapped,
  output logic [DATA_W-1:0] reversed
);
  import bmu_pkg::*;

  logic [DATA_W-1:0] swp_arr [NSIZE];
  logic [DATA_W-1:0] rev_arr [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int W = DATA_W >> (NSIZE - 1 - s);
    localparam int H = W / 2;
    always_comb begin
      swp_arr[s]          = '0;
      swp_arr[s][W-1:0]   = {opnd[H-1:0], opnd[W-1:H]};
      rev_arr[s]          = '0;
      for (int i = 0; i < W; i++) begin
        rev_arr[s][i] = opnd[W-1-i];
      end
    end
  end

  assign swapped  = swp_arr[size];
  assign reversed = rev_arr[size];
endmodule

// File: rtl/bmu_popcnt.sv
module bmu_popcnt #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] vec,
  output logic [CNT_W-1:0]  count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < DATA_W; i++) begin
      count = count + CNT_W'(vec[i]);
    end
  end
endmodule

// File: rtl/bmu_lead.sv
module bmu_lead #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] vec,
  output logic [IDX_W-1:0]  idx,
  output logic              found
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    found = |vec;
  end
endmodule

// File: rtl/bit_manip_unit.sv
module bit_manip_unit #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_size,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_operand,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry
);
  import bmu_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);
  localparam int CNT_W = IDX_W + 1;

  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] opnd_m;
  logic [DATA_W-1:0] swapped, reversed;
  logic [DATA_W-1:0] search_vec;
  logic [CNT_W-1:0]  pop_cnt;
  logic [IDX_W-1:0]  lead_idx;
  logic              lead_found;
  logic [DATA_W-1:0] res_d;
  logic              car_d;
  logic              valid_q;
  logic [DATA_W-1:0] res_q;
  logic              car_q;
  op_e               op;

  assign op = op_e'(in_op);

  always_comb begin
    int w;
    w          = DATA_W >> (NSIZE - 1 - int'(in_size));
    width_mask = ~({DATA_W{1'b1}} << w);
    if (in_size == SZ_QUAD) width_mask = '1;
    opnd_m     = in_operand & width_mask;
  end

  assign search_vec = (op == OP_HCLR) ? (~in_operand & width_mask) : opnd_m;

  bmu_swap_rev #(.DATA_W(DATA_W)) i_swap_rev (
    .opnd     (opnd_m),
    .size     (in_size),
    .swapped  (swapped),
    .reversed (reversed)
  );

  bmu_popcnt #(.DATA_W(DATA_W)) i_popcnt (
    .vec   (opnd_m),
    .count (pop_cnt)
  );

  bmu_lead #(.DATA_W(DATA_W)) i_lead (
    .vec   (search_vec),
    .idx   (lead_idx),
    .found (lead_found)
  );

  // next-state logic
  always_comb begin
    res_d = '0;
    car_d = 1'b0;
    case (op)
      OP_SWAP: res_d = swapped;
      OP_REV:  res_d = reversed;
      OP_POP:  res_d = DATA_W'(pop_cnt);
      OP_HSET,
      OP_HCLR: begin
        res_d = lead_found ? DATA_W'(lead_idx) : '0;
        car_d = ~lead_found;
      end
      OP_NEG:  res_d = (~opnd_m + DATA_W'(1)) & width_mask;
      default: begin
        res_d = '0;
        car_d = 1'b0;
      end
    endcase
  end

  // registers; data loads only on a strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      car_q   <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        car_q <= car_d;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_result = res_q;
  assign out_carry  = car_q;
endmodule

// File: rtl/bmu_chk.sv
module bmu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_size,
  input logic [2:0]        in_op,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_carry
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result) && $stable(out_carry)); // R10
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_carry |-> out_result == '0); // R7
  AST_CARRY_SEARCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op != 3'd3 && in_op != 3'd4 |=> !out_carry); // R7
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size == 2'd0 |=> out_result[DATA_W-1:8] == '0); // R9
  AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == 3'd2 |=> out_result <= DATA_W); // R4
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op[2:1] == 2'b11 |=> out_result == '0 && !out_carry); // R12
endmodule

bind bit_manip_unit bmu_chk #(.DATA_W(DATA_W)) i_bmu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_size    (in_size),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_carry  (out_carry)
);

// File: tb/test_bit_manip_unit.sv
`timescale 1ns/1ps
module test_bit_manip_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_size;
  logic [2:0]  in_op;
  logic [63:0] in_operand;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_carry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bit_manip_unit #(.DATA_W(64)) i_bit_manip_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_size    (in_size),
    .in_op      (in_op),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_carry  (out_carry)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one strobe, checked one edge later
  task automatic run_op(string req, logic [2:0] op, logic [1:0] sz,
                        logic [63:0] opnd, logic [63:0] exp_res, logic exp_c);
    @(negedge clk);
    in_valid   = 1'b1;
    in_op      = op;
    in_size    = sz;
    in_operand = opnd;
    @(negedge clk);
    in_valid   = 1'b0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check({req, " result"}, out_result, exp_res);
    check({req, " carry"}, {63'd0, out_carry}, {63'd0, exp_c});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_size = '0; in_operand = '0;
    #1;
    check("R11 valid in reset", {63'd0, out_valid}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 valid", {63'd0, out_valid}, 64'd0);
    check("R11 result", out_result, 64'd0);
    check("R11 carry", {63'd0, out_carry}, 64'd0);
  endtask

  task automatic t_swap;
    run_op("R1 nibble", 3'd0, 2'd0, 64'hA5, 64'h5A, 1'b0);
    run_op("R1 R9 nibble masked", 3'd0, 2'd0, 64'hFFFF_FF12, 64'h21, 1'b0);
    run_op("R2 word", 3'd0, 2'd1, 64'h1234, 64'h3412, 1'b0);
    run_op("R2 long", 3'd0, 2'd2, 64'hDEAD_0000_1234_5678, 64'h5678_1234, 1'b0);
    run_op("R2 quad", 3'd0, 2'd3, 64'h0123_4567_89AB_CDEF, 64'h89AB_CDEF_0123_4567, 1'b0);
  endtask

  task automatic t_reverse;
    run_op("R3 byte", 3'd1, 2'd0, 64'h01, 64'h80, 1'b0);
    run_op("R3 R9 byte masked", 3'd1, 2'd0, 64'hF0_13, 64'hC8, 1'b0);
    run_op("R3 word", 3'd1, 2'd1, 64'h0001, 64'h8000, 1'b0);
    run_op("R3 quad", 3'd1, 2'd3, 64'h1, 64'h8000_0000_0000_0000, 1'b0);
  endtask

  task automatic t_popcount;
    run_op("R4 quad ones", 3'd2, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 1'b0);
    run_op("R4 R9 byte upper ignored", 3'd2, 2'd0, 64'hFF00, 64'd0, 1'b0);
    run_op("R4 word", 3'd2, 2'd1, 64'hFFFF_0F0F, 64'd8, 1'b0);
    run_op("R4 long", 3'd2, 2'd2, 64'h8000_0001, 64'd2, 1'b0);
  endtask

  task automatic t_highest_set;
    run_op("R5 byte bit0", 3'd3, 2'd0, 64'h01, 64'd0, 1'b0);
    run_op("R5 byte bit7", 3'd3, 2'd0, 64'h81, 64'd7, 1'b0);
    run_op("R5 quad bit63", 3'd3, 2'd3, 64'h8000_0000_0000_0001, 64'd63, 1'b0);
    run_op("R7 word none", 3'd3, 2'd1, 64'h0, 64'd0, 1'b1);
    run_op("R7 R9 byte only upper set", 3'd3, 2'd0, 64'h100, 64'd0, 1'b1);
  endtask

  task automatic t_highest_clear;
    run_op("R6 byte bit7", 3'd4, 2'd0, 64'h7F, 64'd7, 1'b0);
    run_op("R6 word bit0", 3'd4, 2'd1, 64'hFFFE, 64'd0, 1'b0);
    run_op("R7 byte none", 3'd4, 2'd0, 64'hFF, 64'd0, 1'b1);
    run_op("R7 R9 long none", 3'd4, 2'd2, 64'h0000_0000_FFFF_FFFF, 64'd0, 1'b1);
    run_op("R7 quad none", 3'd4, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1);
  endtask

  task automatic t_negate;
    run_op("R8 byte", 3'd5, 2'd0, 64'h01, 64'hFF, 1'b0);
    run_op("R8 R9 byte masked", 3'd5, 2'd0, 64'h1_05, 64'hFB, 1'b0);
    run_op("R8 word zero", 3'd5, 2'd1, 64'h0, 64'h0, 1'b0);
    run_op("R8 long min", 3'd5, 2'd2, 64'h8000_0000, 64'h8000_0000, 1'b0);
    run_op("R8 quad", 3'd5, 2'd3, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
  endtask

  task automatic t_reserved;
    run_op("R12 op6", 3'd6, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0);
    run_op("R12 op7", 3'd7, 2'd0, 64'h55, 64'd0, 1'b0);
  endtask

  task automatic t_timing;
    // back-to-back strobes, then idle with changing inputs
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'd0; in_size = 2'd0; in_operand = 64'h12;
    @(negedge clk);
    check("R10 first valid", {63'd0, out_valid}, 64'd1);
    check("R10 first result", out_result, 64'h21);
    in_op = 3'd2; in_size = 2'd3; in_operand = 64'hF;
    @(negedge clk);
    in_valid = 1'b0; in_operand = 64'hFFFF; in_op = 3'd5;
    check("R10 second result", out_result, 64'd4);
    @(negedge clk);
    check("R10 idle valid low", {63'd0, out_valid}, 64'd0);
    check("R10 idle result held", out_result, 64'd4);
  endtask

  initial begin
    t_reset();
    t_swap();
    t_reverse();
    t_popcount();
    t_highest_set();
    t_highest_clear();
    t_negate();
    t_reserved();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule